// File: doc/BRIEF.md
# DMA Completion Interrupt Coalescer

This unit thins out the stream of per-packet completion interrupts a DMA channel would otherwise raise. A packet counter is loaded from a programmable threshold and counts down once per finished packet; when the last packet of a batch finishes, the unit emits a one-cycle request to set the completion-interrupt status bit and reloads the counter for the next batch.

Traffic that stops part-way through a batch would leave packets unreported. A one-shot delay timer covers this case. Each finished packet restarts it from a programmable delay value. It counts down on a prescaled tick, which by default runs at 50 MHz. If no further packet arrives before it runs out, it emits a one-cycle request to set the delay-interrupt status bit and restarts the batch.

The threshold and delay fields come from the channel's control register, which is held outside this unit, as are interrupt masking and the status bits. The live counter and timer values are driven out so the status register can show them.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the packet counter reads 1, the delay timer reads 0, and both set pulses are low.
- R2: A completion that does not finish a batch and that coincides with no reload lowers the packet counter by exactly one and raises no completion pulse.
- R3: A completion while the packet counter reads 1 raises `cmpl_irq_set` for exactly the following cycle and reloads the counter from the threshold (control bits 23:16, given on `thresh_fld`).
- R4: A threshold of 0 is used as 1, so the counter never reads 0 and every completion then raises `cmpl_irq_set`.
- R5: A cycle with `ctrl_wr` high reloads the packet counter from the threshold.
- R6: A completion loads the delay timer with the delay value (control bits 31:24, given on `delay_fld`) when that value is nonzero. When it is zero, the timer is left as it was.
- R7: The delay timer drops by one only in cycles with `tick` high and the timer nonzero. It holds otherwise.
- R8: A tick while the timer reads 1 raises `delay_irq_set` for exactly the following cycle, leaves the timer at 0 and reloads the packet counter from the threshold.
- R9: The timer is one-shot. Once at 0 it stays at 0 through any number of ticks and raises no delay pulse until a completion restarts it.
- R10: When a completion at counter 1 and a timer expiry fall in the same cycle, both pulses are raised and the timer restarts from the delay value.
- R11: A reload (a control write or a timer expiry) wins over a same-cycle decrement: the counter takes the threshold value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_done | input | 1 | One-cycle pulse per finished packet |
| thresh_fld | input | 8 | Completion threshold field of the control register |
| delay_fld | input | 8 | Delay field of the control register |
| ctrl_wr | input | 1 | Control-register write strobe |
| tick | input | 1 | Prescaled timer tick enable |
| cmpl_irq_set | output | 1 | Pulse that sets the completion-interrupt status bit |
| delay_irq_set | output | 1 | Pulse that sets the delay-interrupt status bit |
| pkt_count | output | 8 | Live packet counter for status read-back |
| delay_count | output | 8 | Live delay timer for status read-back |

## Verification
The assertions assume that `pkt_done`, `ctrl_wr` and `tick` are synchronous single-cycle strobes. They also assume that the threshold and delay fields are stable around any cycle whose reload they feed, because the decrement and reload checks compare against the previous cycle's field values. The stimulus changes the fields and raises strobes only on the falling edge, and holds them across the rising edge. It changes a field without a write only to set up the delay-zero and coincidence cases, and in those cases the new value is the one the following edge is meant to use.

// File: rtl/coal_pkg.sv
// Package: shared types of the interrupt coalescer.
// Assumes: nothing beyond IEEE 1800-2017.
package coal_pkg;

    // Next action for the packet counter in a cycle.
    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_DEC    = 2'd1,
        CNT_RELOAD = 2'd2
    } cnt_act_e;

endpackage

// File: rtl/coal_pkt_counter.sv
// Module: packet batch counter. Counts finished packets down from the
// threshold. When the batch ends it emits a registered completion set pulse
// and reloads the counter. An external reload request wins over a decrement.
// Assumes: pkt_done and reload_req are single-cycle synchronous strobes.
module coal_pkt_counter
    import coal_pkg::*;
#(
    parameter int THR_W   = 8,
    parameter int RST_THR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             reload_req,
    input  logic [THR_W-1:0] thresh,
    output logic [THR_W-1:0] count,
    output logic             cmpl_set
);
    localparam logic [THR_W-1:0] ONE     = THR_W'(1);
    localparam logic [THR_W-1:0] RST_VAL = THR_W'(RST_THR);

    logic [THR_W-1:0] thr_eff;
    logic             batch_end;
    cnt_act_e         act;

    // Saturate a zero threshold to one so the counter never wraps.
    always_comb thr_eff = (thresh == '0) ? ONE : thresh;

    // A completion at the last packet of the batch.
    always_comb batch_end = pkt_done && (count == ONE);

    // Pick the counter action: reload beats decrement.
    always_comb begin
        if (reload_req || batch_end) act = CNT_RELOAD;
        else if (pkt_done)           act = CNT_DEC;
        else                         act = CNT_HOLD;
    end

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= RST_VAL;
        end else begin
            case (act)
                CNT_RELOAD: count <= thr_eff;
                CNT_DEC:    count <= count - ONE;
                default:    count <= count;
            endcase
        end
    end

    // Registered completion set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cmpl_set <= 1'b0;
        else        cmpl_set <= batch_end;
    end

    // R4
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0);

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !reload_req && count > ONE)
        |=> (count == THR_W'($past(count) - ONE)) && !cmpl_set);

    // R5
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> count == (($past(thresh) == '0) ? ONE : $past(thresh)));

    // R3
    cmpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && count == ONE) |=> cmpl_set);

endmodule

// File: rtl/coal_delay_timer.sv
// Module: one-shot delay timer. Each completion with a nonzero delay reloads
// it. It counts down on tick. When it reaches zero it emits a registered
// delay set pulse and stops.
// Assumes: tick is a synchronous single-cycle enable from a prescaler.
module coal_delay_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             tick,
    input  logic [DLY_W-1:0] delay,
    output logic [DLY_W-1:0] timer,
    output logic             expire,
    output logic             delay_set
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    logic restart;
    logic running;

    // Restart only when a completion brings a nonzero delay.
    always_comb restart = pkt_done && (delay != '0);

    // The timer is armed while it holds a nonzero value.
    always_comb running = (timer != '0);

    // Expiry: the last tick of an armed timer.
    always_comb expire = tick && (timer == ONE);

    // Timer register: restart wins over countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)                timer <= '0;
        else if (restart)          timer <= delay;
        else if (tick && running)  timer <= timer - ONE;
    end

    // Registered delay set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) delay_set <= 1'b0;
        else        delay_set <= expire;
    end

    // R6
    tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && delay != '0) |=> timer == $past(delay));

    // R7
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pkt_done) |=> $stable(timer));

    // R9
    tmr_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer == '0 && !pkt_done) |=> (timer == '0) && !delay_set);

    // R8
    tmr_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && timer == ONE) |=> delay_set);

endmodule

// File: rtl/irq_coalescer.sv
// Module: DMA completion interrupt coalescer top. Joins the packet counter
// and the delay timer. A timer expiry or a control write reloads the counter.
// Assumes: the threshold and delay fields come from an external control
// register, and masking and status storage live outside this unit.
module irq_coalescer #(
    parameter int THR_W   = 8,
    parameter int DLY_W   = 8,
    parameter int RST_THR = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [THR_W-1:0] thresh_fld,
    input  logic [DLY_W-1:0] delay_fld,
    input  logic             ctrl_wr,
    input  logic             tick,
    output logic             cmpl_irq_set,
    output logic             delay_irq_set,
    output logic [THR_W-1:0] pkt_count,
    output logic [DLY_W-1:0] delay_count
);
    logic tmr_expire;
    logic cnt_reload;

    // A control write or a timer expiry restarts the batch.
    always_comb cnt_reload = ctrl_wr || tmr_expire;

    coal_pkt_counter #(
        .THR_W   (THR_W),
        .RST_THR (RST_THR)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_done   (pkt_done),
        .reload_req (cnt_reload),
        .thresh     (thresh_fld),
        .count      (pkt_count),
        .cmpl_set   (cmpl_irq_set)
    );

    coal_delay_timer #(
        .DLY_W (DLY_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_done  (pkt_done),
        .tick      (tick),
        .delay     (delay_fld),
        .timer     (delay_count),
        .expire    (tmr_expire),
        .delay_set (delay_irq_set)
    );

    // R10
    both_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_count == THR_W'(1) && tick && delay_count == DLY_W'(1))
        |=> cmpl_irq_set && delay_irq_set);

    // R8
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && delay_count == DLY_W'(1))
        |=> pkt_count == (($past(thresh_fld) == '0) ? THR_W'(1) : $past(thresh_fld)));

endmodule

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_done = 1'b0;
    logic [7:0] thresh_fld = 8'd1;
    logic [7:0] delay_fld = 8'd0;
    logic       ctrl_wr = 1'b0;
    logic       tick = 1'b0;
    logic       cmpl_irq_set;
    logic       delay_irq_set;
    logic [7:0] pkt_count;
    logic [7:0] delay_count;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    irq_coalescer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_done      (pkt_done),
        .thresh_fld    (thresh_fld),
        .delay_fld     (delay_fld),
        .ctrl_wr       (ctrl_wr),
        .tick          (tick),
        .cmpl_irq_set  (cmpl_irq_set),
        .delay_irq_set (delay_irq_set),
        .pkt_count     (pkt_count),
        .delay_count   (delay_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: strobes set on entry act on the next rising edge and are
    // cleared at the following falling edge, where outputs are sampled.
    task automatic cycle(input bit d, input bit w, input bit t);
        pkt_done = d; ctrl_wr = w; tick = t;
        @(negedge clk);
        pkt_done = 1'b0; ctrl_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", pkt_count, 1);
        check("R1 timer", delay_count, 0);
        check("R1 cmpl", cmpl_irq_set, 0);
        check("R1 delay", delay_irq_set, 0);
    endtask

    task automatic t_batch();
        thresh_fld = 8'd3; delay_fld = 8'd0;
        cycle(0, 1, 0);
        check("R5 reload", pkt_count, 3);
        cycle(1, 0, 0);
        check("R2 dec", pkt_count, 2);
        check("R2 no pulse", cmpl_irq_set, 0);
        cycle(1, 0, 0);
        check("R2 dec", pkt_count, 1);
        cycle(1, 0, 0);
        check("R3 pulse", cmpl_irq_set, 1);
        check("R3 reload", pkt_count, 3);
        cycle(0, 0, 0);
        check("R3 single", cmpl_irq_set, 0);
    endtask

    task automatic t_zero_thr();
        thresh_fld = 8'd0;
        cycle(0, 1, 0);
        check("R4 count", pkt_count, 1);
        cycle(1, 0, 0);
        check("R4 pulse", cmpl_irq_set, 1);
        check("R4 count", pkt_count, 1);
        cycle(1, 0, 0);
        check("R4 pulse2", cmpl_irq_set, 1);
        cycle(0, 0, 0);
    endtask

    task automatic t_timer();
        thresh_fld = 8'd5; delay_fld = 8'd4;
        cycle(0, 1, 0);
        cycle(1, 0, 0);
        check("R6 load", delay_count, 4);
        check("R2 dec", pkt_count, 4);
        cycle(0, 0, 0);
        check("R7 hold", delay_count, 4);
        cycle(0, 0, 1);
        check("R7 tick", delay_count, 3);
        cycle(0, 0, 1);
        cycle(0, 0, 1);
        check("R7 tick", delay_count, 1);
        check("R8 quiet", delay_irq_set, 0);
        cycle(0, 0, 1);
        check("R8 pulse", delay_irq_set, 1);
        check("R8 timer", delay_count, 0);
        check("R8 reload", pkt_count, 5);
        cycle(0, 0, 1);
        check("R8 single", delay_irq_set, 0);
        check("R9 stopped", delay_count, 0);
        cycle(0, 0, 1);
        check("R9 no pulse", delay_irq_set, 0);
    endtask

    task automatic t_zero_delay_and_both();
        thresh_fld = 8'd5; delay_fld = 8'd6;
        cycle(0, 1, 0);
        cycle(1, 0, 0);
        check("R6 load", delay_count, 6);
        delay_fld = 8'd0;
        cycle(1, 0, 0);
        check("R6 keep", delay_count, 6);
        check("R2 dec", pkt_count, 3);
        for (int i = 0; i < 5; i++) cycle(0, 0, 1);
        check("R7 tick", delay_count, 1);
        thresh_fld = 8'd1; delay_fld = 8'd7;
        cycle(0, 1, 0);
        check("R5 reload", pkt_count, 1);
        check("R7 hold", delay_count, 1);
        cycle(1, 0, 1);
        check("R10 cmpl", cmpl_irq_set, 1);
        check("R10 delay", delay_irq_set, 1);
        check("R10 restart", delay_count, 7);
        check("R10 count", pkt_count, 1);
        cycle(0, 0, 0);
    endtask

    task automatic t_reload_wins();
        thresh_fld = 8'd4; delay_fld = 8'd0;
        cycle(0, 1, 0);
        cycle(1, 0, 0);
        check("R2 dec", pkt_count, 3);
        cycle(1, 1, 0);
        check("R11 write wins", pkt_count, 4);
        check("R11 no pulse", cmpl_irq_set, 0);
        // Expiry against a decrement: timer 7 counts down to 1.
        for (int i = 0; i < 6; i++) cycle(0, 0, 1);
        check("R7 tick", delay_count, 1);
        cycle(1, 0, 1);
        check("R11 expiry wins", pkt_count, 4);
        check("R8 pulse", delay_irq_set, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_batch();
        t_zero_thr();
        t_timer();
        t_zero_delay_and_both();
        t_reload_wins();
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule